// File: doc/BRIEF.md
# Fixed Off-Time Current Chopper

This block regulates the winding current of one motor H-bridge. While enabled it turns on one diagonal of the bridge, so the current rises. It keeps the drive on until a digital trip signal says the sensed current has reached its threshold. The trip signal comes from an external comparator. On a trip the block leaves the drive off for a programmed number of clock cycles, with the winding recirculating in brake or coast, and then starts a new on phase by itself. There is no fixed PWM frequency: each on phase lasts until the next trip.

Every on phase opens with a blanking window in which the comparator is ignored. This window is the shortest on-time a drive pulse can have. The block also selects the reference level for the comparator, full scale or half scale, from a torque-select input. It emits a single-cycle pulse for each trip that ends an on phase.

Top module: `fixed_toff_chopper`

## Requirements
- R1: During and right after reset all gate outputs are low (coast), `tripPulse` is 0 and `refHalf` is 0.
- R2: In an on phase the direction captured at that phase's start selects the diagonal. Bit 0 of each gate vector is half-bridge A and bit 1 is half-bridge B. Direction 0 gives `gateHi`=01 and `gateLo`=10. Direction 1 gives `gateHi`=10 and `gateLo`=01.
- R3: The first max(`blankCycles`,1) cycles of an on phase ignore the trip input. A trip that is already present when blanking ends gives an on-time of exactly max(`blankCycles`,1)+1 cycles.
- R4: The trip input passes through a two-flop synchroniser. When it rises during sensing, the drive turns off on the third rising clock edge after that.
- R5: The off phase lasts max(`offCycles`,1) cycles. A new on phase, blanking first, then starts without any other stimulus.
- R6: During the off phase, `decayBrake`=1 sets `gateLo`=11 and `gateHi`=00 (brake). `decayBrake`=0 sets all gates to 0 (coast).
- R7: `tripPulse` is high for exactly one cycle, the first off cycle, for each trip that ends an on phase. It never rises while the drive is on.
- R8: With `enable` low, all gates are 0 in the same cycle, without waiting for a clock edge, and the timers are cleared. Raising `enable` again starts a fresh on phase with full blanking.
- R9: A change of `dirReq`, `blankCycles` or `offCycles` takes effect only at the start of the next on phase.
- R10: `refHalf` follows `torqueSel` one clock later. A value of 1 asks for a 50 percent trip level and 0 asks for 100 percent.
- R11: No half-bridge has its high-side and low-side gates on at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| enable | input | 1 | Bridge enable |
| dirReq | input | 1 | Direction request (0 = A high/B low) |
| torqueSel | input | 1 | Torque scale select (1 = half scale) |
| decayBrake | input | 1 | Off-phase recirculation: 1 = brake, 0 = coast |
| tripRaw | input | 1 | Asynchronous trip from the current comparator |
| blankCycles | input | CNT_W | Blanking length in cycles (0 acts as 1) |
| offCycles | input | CNT_W | Off-time length in cycles (0 acts as 1) |
| gateHi | output | 2 | High-side gate enables, bit0 = half-bridge A |
| gateLo | output | 2 | Low-side gate enables, bit0 = half-bridge A |
| refHalf | output | 1 | Reference level select to the comparator |
| tripPulse | output | 1 | One-cycle pulse per accepted trip |

## Verification
The end of blanking and the acceptance of a trip can fall on the same cycle. The bench provokes this by holding the trip input high from the moment the bridge is enabled, so the synchronised trip is already waiting when blanking expires. Each on-time must then equal the blanking length plus one sensing cycle, off times must repeat at the programmed length, and `tripPulse` must land on the first off cycle. Mid-phase edits to the blanking, off-time and direction inputs check that the running phase keeps its captured values.

// File: rtl/chop_pkg.sv
package chop_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_BLANK = 2'd1,
    ST_SENSE = 2'd2,
    ST_OFF   = 2'd3
  } chopState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic loadCfg;   // capture direction and timing at on-phase start
    logic clrCnt;    // zero the phase counter
    logic cmpOff;    // compare counter with off-time (else blanking)
    logic driveOn;   // bridge drives the captured diagonal
    logic recirc;    // bridge in off-phase recirculation
    logic tripEvt;   // an accepted trip ends the on phase now
  } chopStrobe_t;

  localparam int unsigned NUM_LEGS = 2;

endpackage

// File: rtl/chop_ctrl.sv
module chop_ctrl
  import chop_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        enable,
  input  logic        tripSync,
  input  logic        cntDone,
  output chopStrobe_t strobe
);

  chopState_t state, stateNxt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNxt;
  end

  always_comb begin
    stateNxt = state;
    strobe   = '0;
    unique case (state)
      ST_IDLE: begin
        strobe.clrCnt = 1'b1;
        if (enable) begin
          stateNxt       = ST_BLANK;
          strobe.loadCfg = 1'b1;
        end
      end
      ST_BLANK: begin
        strobe.driveOn = 1'b1;
        if (cntDone) begin
          stateNxt      = ST_SENSE;
          strobe.clrCnt = 1'b1;
        end
      end
      ST_SENSE: begin
        strobe.driveOn = 1'b1;
        strobe.clrCnt  = 1'b1;
        if (tripSync) begin
          stateNxt       = ST_OFF;
          strobe.tripEvt = 1'b1;
        end
      end
      ST_OFF: begin
        strobe.recirc = 1'b1;
        strobe.cmpOff = 1'b1;
        if (cntDone) begin
          stateNxt       = ST_BLANK;
          strobe.loadCfg = 1'b1;
          strobe.clrCnt  = 1'b1;
        end
      end
      default: stateNxt = ST_IDLE;
    endcase
    if (!enable) begin
      stateNxt       = ST_IDLE;
      strobe.clrCnt  = 1'b1;
      strobe.loadCfg = 1'b0;
      strobe.tripEvt = 1'b0;
    end
  end

endmodule

// File: rtl/chop_dpath.sv
module chop_dpath
  import chop_pkg::*;
#(
  parameter int unsigned CNT_W       = 12,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                enable,
  input  logic                dirReq,
  input  logic                torqueSel,
  input  logic                decayBrake,
  input  logic                tripRaw,
  input  logic [CNT_W-1:0]    blankCycles,
  input  logic [CNT_W-1:0]    offCycles,
  input  chopStrobe_t         strobe,
  output logic                tripSync,
  output logic                cntDone,
  output logic [NUM_LEGS-1:0] gateHi,
  output logic [NUM_LEGS-1:0] gateLo,
  output logic                refHalf,
  output logic                tripPulse
);

  localparam int unsigned EXT_W = CNT_W + 1;
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  // trip synchroniser
  logic [SYNC_STAGES-1:0] syncReg;
  generate
    if (SYNC_STAGES == 1) begin : g_sync1
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncReg <= '0;
        else       syncReg <= tripRaw;
      end
    end else begin : g_syncN
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncReg <= '0;
        else       syncReg <= {syncReg[SYNC_STAGES-2:0], tripRaw};
      end
    end
  endgenerate
  assign tripSync = syncReg[SYNC_STAGES-1];

  // captured phase configuration
  logic [CNT_W-1:0] blankLat, offLat;
  logic             dirLat;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      blankLat <= ONE;
      offLat   <= ONE;
      dirLat   <= 1'b0;
    end else if (strobe.loadCfg) begin
      blankLat <= (blankCycles == '0) ? ONE : blankCycles;
      offLat   <= (offCycles == '0) ? ONE : offCycles;
      dirLat   <= dirReq;
    end
  end

  // phase counter
  logic [CNT_W-1:0] phaseCnt;
  logic [EXT_W-1:0] cntNext, cntLimit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              phaseCnt <= '0;
    else if (strobe.clrCnt) phaseCnt <= '0;
    else                    phaseCnt <= phaseCnt + ONE;
  end

  assign cntNext  = {1'b0, phaseCnt} + EXT_W'(1);
  assign cntLimit = {1'b0, (strobe.cmpOff ? offLat : blankLat)};
  assign cntDone  = (cntNext >= cntLimit);

  // gate decode
  logic [NUM_LEGS-1:0] diagHi, diagLo;
  assign diagHi = dirLat ? 2'b10 : 2'b01;
  assign diagLo = ~diagHi;

  always_comb begin
    gateHi = '0;
    gateLo = '0;
    if (enable) begin
      if (strobe.driveOn) begin
        gateHi = diagHi;
        gateLo = diagLo;
      end else if (strobe.recirc && decayBrake) begin
        gateLo = '1;
      end
    end
  end

  // registered side outputs
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      refHalf   <= 1'b0;
      tripPulse <= 1'b0;
    end else begin
      refHalf   <= torqueSel;
      tripPulse <= strobe.tripEvt;
    end
  end

endmodule

// File: rtl/fixed_toff_chopper.sv
module fixed_toff_chopper
  import chop_pkg::*;
#(
  parameter int unsigned CNT_W       = 12,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             enable,
  input  logic             dirReq,
  input  logic             torqueSel,
  input  logic             decayBrake,
  input  logic             tripRaw,
  input  logic [CNT_W-1:0] blankCycles,
  input  logic [CNT_W-1:0] offCycles,
  output logic [1:0]       gateHi,
  output logic [1:0]       gateLo,
  output logic             refHalf,
  output logic             tripPulse
);

  chopStrobe_t strobe;
  logic        tripSync;
  logic        cntDone;

  chop_ctrl i_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .enable   (enable),
    .tripSync (tripSync),
    .cntDone  (cntDone),
    .strobe   (strobe)
  );

  chop_dpath #(
    .CNT_W       (CNT_W),
    .SYNC_STAGES (SYNC_STAGES)
  ) i_dpath (
    .clk         (clk),
    .rstN        (rstN),
    .enable      (enable),
    .dirReq      (dirReq),
    .torqueSel   (torqueSel),
    .decayBrake  (decayBrake),
    .tripRaw     (tripRaw),
    .blankCycles (blankCycles),
    .offCycles   (offCycles),
    .strobe      (strobe),
    .tripSync    (tripSync),
    .cntDone     (cntDone),
    .gateHi      (gateHi),
    .gateLo      (gateLo),
    .refHalf     (refHalf),
    .tripPulse   (tripPulse)
  );

endmodule

// File: rtl/chop_checker.sv
module chop_checker (
  input logic       clk,
  input logic       rstN,
  input logic       enable,
  input logic       torqueSel,
  input logic [1:0] gateHi,
  input logic [1:0] gateLo,
  input logic       refHalf,
  input logic       tripPulse
);

  p_no_shoot_r11: assert property (@(posedge clk) disable iff (!rstN)
    (gateHi & gateLo) == 2'b00);

  p_coast_disabled_r8: assert property (@(posedge clk) disable iff (!rstN)
    !enable |-> (gateHi == 2'b00 && gateLo == 2'b00));

  p_ref_follow_r10: assert property (@(posedge clk) disable iff (!rstN)
    (rstN && $past(rstN)) |-> (refHalf == $past(torqueSel)));

  p_pulse_off_r7: assert property (@(posedge clk) disable iff (!rstN)
    tripPulse |-> (gateHi == 2'b00));

  p_pulse_single_r7: assert property (@(posedge clk) disable iff (!rstN)
    tripPulse |=> !tripPulse);

  p_min_on_r3: assert property (@(posedge clk) disable iff (!rstN)
    (enable && $past(enable) && ($past(gateHi) != 2'b00) && ($past(gateHi, 2) == 2'b00))
      |-> (gateHi != 2'b00));

endmodule

bind fixed_toff_chopper chop_checker i_chk (
  .clk       (clk),
  .rstN      (rstN),
  .enable    (enable),
  .torqueSel (torqueSel),
  .gateHi    (gateHi),
  .gateLo    (gateLo),
  .refHalf   (refHalf),
  .tripPulse (tripPulse)
);

// File: tb/test_fixed_toff_chopper.sv
module test_fixed_toff_chopper;

  localparam int CW = 12;
  localparam logic [3:0] FWD = 4'b0110;   // {gateHi,gateLo} direction 0
  localparam logic [3:0] REV = 4'b1001;   // direction 1
  localparam logic [3:0] BRK = 4'b0011;
  localparam logic [3:0] CST = 4'b0000;

  logic clk = 1'b0;
  logic rstN, enable, dirReq, torqueSel, decayBrake, tripRaw;
  logic [CW-1:0] blankCycles, offCycles;
  logic [1:0] gateHi, gateLo;
  logic refHalf, tripPulse;

  int nCmp = 0;
  int nBad = 0;

  always #4 clk = ~clk;

  fixed_toff_chopper #(.CNT_W(CW), .SYNC_STAGES(2)) i_fixed_toff_chopper (
    .clk(clk), .rstN(rstN), .enable(enable), .dirReq(dirReq),
    .torqueSel(torqueSel), .decayBrake(decayBrake), .tripRaw(tripRaw),
    .blankCycles(blankCycles), .offCycles(offCycles),
    .gateHi(gateHi), .gateLo(gateLo), .refHalf(refHalf), .tripPulse(tripPulse)
  );

  task automatic chk(input string req, input int act, input int exp);
    nCmp++;
    if (act != exp) begin
      nBad++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int gates();
    return int'({gateHi, gateLo});
  endfunction

  task automatic idleFor(input int n);
    @(negedge clk);
    enable = 1'b0;
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic testReset();
    rstN = 1'b0; enable = 1'b0; dirReq = 1'b0; torqueSel = 1'b0;
    decayBrake = 1'b0; tripRaw = 1'b0; blankCycles = '0; offCycles = '0;
    repeat (3) @(negedge clk);
    chk("R1 gates", gates(), 0);
    chk("R1 tripPulse", int'(tripPulse), 0);
    chk("R1 refHalf", int'(refHalf), 0);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 gates after release", gates(), 0);
  endtask

  // trip held high: on = B+1, off = O, repeating
  task automatic testCyclic(input int b, input int o, input bit dir, input bit brake, input int n);
    int be, oe, per, ph;
    logic [3:0] on, off;
    be = (b == 0) ? 1 : b;
    oe = (o == 0) ? 1 : o;
    per = be + 1 + oe;
    on = dir ? REV : FWD;
    off = brake ? BRK : CST;
    idleFor(1);
    blankCycles = CW'(b); offCycles = CW'(o); dirReq = dir;
    decayBrake = brake; tripRaw = 1'b1;
    repeat (3) @(negedge clk);
    enable = 1'b1;
    for (int k = 1; k <= n; k++) begin
      @(negedge clk);
      ph = (k - 1) % per;
      chk((ph <= be) ? "R3 R2 on phase" : "R5 R6 off phase", gates(), int'((ph <= be) ? on : off));
      chk("R7 trip pulse", int'(tripPulse), (ph == be + 1) ? 1 : 0);
    end
    tripRaw = 1'b0;
  endtask

  task automatic testBlankIgnore();
    idleFor(3);
    blankCycles = CW'(8); offCycles = CW'(2); dirReq = 1'b0; tripRaw = 1'b0;
    enable = 1'b1;
    for (int k = 1; k <= 20; k++) begin
      @(negedge clk);
      chk("R3 blanking ignores trip", gates(), int'(FWD));
      chk("R3 no pulse in blank", int'(tripPulse), 0);
      if (k == 1) tripRaw = 1'b1;
      if (k == 3) tripRaw = 1'b0;
    end
  endtask

  task automatic testSyncLatency();
    idleFor(3);
    blankCycles = CW'(3); offCycles = CW'(2); dirReq = 1'b1;
    decayBrake = 1'b0; tripRaw = 1'b0;
    enable = 1'b1;
    repeat (8) @(negedge clk);
    chk("R2 reverse drive", gates(), int'(REV));
    tripRaw = 1'b1;
    @(negedge clk); chk("R4 sync stage 1", gates(), int'(REV));
    @(negedge clk); chk("R4 sync stage 2", gates(), int'(REV));
    @(negedge clk); chk("R4 off on third edge", gates(), int'(CST));
    chk("R7 pulse on first off", int'(tripPulse), 1);
    tripRaw = 1'b0;
    @(negedge clk); chk("R7 pulse one cycle", int'(tripPulse), 0);
    chk("R6 coast off", gates(), int'(CST));
    @(negedge clk); chk("R5 new on phase", gates(), int'(REV));
  endtask

  task automatic testEnableDrop();
    idleFor(3);
    blankCycles = CW'(3); offCycles = CW'(2); dirReq = 1'b0;
    decayBrake = 1'b1; tripRaw = 1'b0;
    enable = 1'b1;
    repeat (6) @(negedge clk);
    chk("R8 driving before drop", gates(), int'(FWD));
    enable = 1'b0;
    #1 chk("R8 immediate coast", gates(), 0);
    @(negedge clk); chk("R8 stays coast", gates(), 0);
    tripRaw = 1'b1;
    @(negedge clk); chk("R8 stays coast 2", gates(), 0);
    @(negedge clk);
    enable = 1'b1;
    for (int k = 1; k <= 6; k++) begin
      @(negedge clk);
      chk("R8 fresh blanking", gates(), int'((k <= 4) ? FWD : BRK));
      chk("R8 pulse after fresh blank", int'(tripPulse), (k == 5) ? 1 : 0);
    end
    tripRaw = 1'b0;
  endtask

  task automatic testDirChange();
    idleFor(3);
    blankCycles = CW'(2); offCycles = CW'(2); dirReq = 1'b0;
    decayBrake = 1'b1; tripRaw = 1'b0;
    enable = 1'b1;
    repeat (5) @(negedge clk);
    dirReq = 1'b1;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk("R9 direction held mid-phase", gates(), int'(FWD));
    end
    tripRaw = 1'b1;
    repeat (3) @(negedge clk);
    tripRaw = 1'b0;
    chk("R6 brake off", gates(), int'(BRK));
    @(negedge clk); chk("R5 off second cycle", gates(), int'(BRK));
    @(negedge clk); chk("R9 new direction next phase", gates(), int'(REV));
  endtask

  task automatic testCfgChange();
    int exp;
    idleFor(1);
    blankCycles = CW'(6); offCycles = CW'(2); dirReq = 1'b0;
    decayBrake = 1'b1; tripRaw = 1'b1;
    repeat (3) @(negedge clk);
    enable = 1'b1;
    for (int k = 1; k <= 14; k++) begin
      @(negedge clk);
      exp = ((k <= 7) || (k >= 10 && k <= 12)) ? int'(FWD) : int'(BRK);
      chk("R9 blank change at next phase", gates(), exp);
      chk("R9 pulse timing", int'(tripPulse), (k == 8 || k == 13) ? 1 : 0);
      if (k == 2) blankCycles = CW'(2);
    end
    tripRaw = 1'b0;
  endtask

  task automatic testTorque();
    @(negedge clk);
    torqueSel = 1'b1;
    @(negedge clk); chk("R10 half scale", int'(refHalf), 1);
    torqueSel = 1'b0;
    @(negedge clk); chk("R10 full scale", int'(refHalf), 0);
  endtask

  initial begin
    #(8 * 100000);
    nBad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end

  initial begin
    testReset();
    testCyclic(4, 3, 1'b0, 1'b1, 24);
    testCyclic(1, 1, 1'b1, 1'b0, 12);
    testCyclic(0, 0, 1'b0, 1'b1, 9);
    testBlankIgnore();
    testSyncLatency();
    testEnableDrop();
    testDirChange();
    testCfgChange();
    testTorque();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end

endmodule